// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block runs the digital side of a four-channel converter whose inputs are sampled at one instant. A rising edge on the start input freezes all four sample-holds together. The block then converts the enabled channels one after another, lowest channel number first, and stores each 14-bit code in that channel's result slot. The conversion core is modelled as a fixed count of 16 conversion-clock ticks, and its code is the value presented on the channel's input bus at the moment of hold.

A mode pin chooses where the enabled-channel set comes from. With the pin low, the set comes from four select pins and the conversion clock is always the system clock. With the pin high, the set comes from a 4-bit software register, and a clock-select pin can switch the conversion clock to an external tick enable. A standby input parks the block in a power-save state.

The control FSM has four states. `ST_IDLE` waits for a start edge. `ST_SCAN` picks the first enabled channel. `ST_CONV` counts conversion ticks. `ST_SLEEP` is power-save. The transitions are:
- IDLE→SCAN on an accepted start.
- IDLE→SLEEP when standby is low.
- SCAN→CONV when a channel is pending.
- SCAN→IDLE when the set is empty.
- CONV→CONV when a conversion ends and another channel is pending.
- CONV→IDLE when the last conversion ends.
- SLEEP→IDLE when standby returns high.

Top module: `ssc_seq_top`

## Requirements
- R1: A 0→1 change of `start_i` between two clock samples, seen in ST_IDLE with `standby_n_i` high, is accepted. On the edge of acceptance (E0), `busy_o` and all four `hold_o` bits go high, and every channel's `ain_i` value is captured. `hold_o` is always either all ones or all zeros, and equals all ones exactly while `busy_o` is high.
- R2: The enabled-channel set and the clock choice are latched at E0. Later changes to the select pins, the software register or `ain_i` do not alter the running sequence or its codes.
- R3: With `mode_sw_i`=0, bit i of `pin_sel_i` enables channel i (1 = converted). The software register is ignored, and the system clock is used whatever `ext_clk_sel_i` and `ext_tick_i` do.
- R4: With `mode_sw_i`=1, the set is the software register, where bit i enables channel i. A cycle with `reg_wr_i`=1 loads `reg_wdata_i` into the register, and its reset value is 4'hF. If `ext_clk_sel_i`=1 at E0, conversion ticks occur only on edges where `ext_tick_i`=1; otherwise every clock edge is a tick.
- R5: Conversions run in ascending channel order, and disabled channels take no cycles. Tick counting starts at edge E2, and each conversion ends on its 16th tick. The next conversion's ticks start on the following edge. With the system clock, the j-th conversion ends on edge E(1+16j).
- R6: `eoc_o` is high for exactly the one cycle after each conversion-ending edge. `busy_o` falls on the edge that ends the last conversion.
- R7: On the edge that ends channel i's conversion, result slot i of `res_o` (bits 14i+13:14i) takes the code held for channel i. Other slots keep their value, and all slots reset to 0.
- R8: With an empty set, `busy_o` is high only for the cycle after E0 and falls at E1. No `eoc_o` pulse occurs.
- R9: A start edge while `busy_o` is high is ignored.
- R10: With `standby_n_i` low in ST_IDLE, the block enters ST_SLEEP on the next edge and `pwr_save_o` goes high. Start edges are ignored there. Raising `standby_n_i` returns the block to ST_IDLE on the next edge. A standby request made during a sequence takes effect after the sequence ends.
- R11: After reset, `busy_o`, `eoc_o`, `hold_o` and `pwr_save_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; rising edge begins a sequence |
| mode_sw_i | input | 1 | 0: pin-selected set, system clock; 1: register set |
| pin_sel_i | input | 4 | Channel enable pins, bit i = channel i |
| ext_clk_sel_i | input | 1 | In register mode, 1 selects external ticks |
| ext_tick_i | input | 1 | External conversion clock as a tick enable |
| reg_wr_i | input | 1 | Software register write strobe |
| reg_wdata_i | input | 4 | Software register write data |
| standby_n_i | input | 1 | Low requests power-save |
| ain_i | input | 56 | Per-channel input codes, channel i in bits 14i+13:14i |
| hold_o | output | 4 | Sample-hold controls, 1 = hold |
| busy_o | output | 1 | Sequence in progress |
| eoc_o | output | 1 | One-cycle pulse per finished conversion |
| res_o | output | 56 | Result slots, channel i in bits 14i+13:14i |
| pwr_save_o | output | 1 | Block is in power-save |

## Verification
`busy_o` and `hold_o` are due one edge after the start edge. Each `eoc_o` and its slot write are due on the edge that carries the 16th tick of that conversion, counting from E2. The bench advances an edge index, adds up the ticks it drove for each edge, and predicts `busy_o`, `eoc_o`, `hold_o` and the slot being written for every edge. It compares these at the falling clock edge that follows. The untouched slots, the `pwr_save_o` transitions and the ignored starts are checked at the ports after the stimulus that could have disturbed them.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CONV  = 2'd2,
        ST_SLEEP = 2'd3
    } ssc_state_e;
endpackage

// File: rtl/ssc_start_gate.sv
module ssc_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic rise_o
);
    logic start_d;

    always_ff @(posedge clk) begin
        if (!rst_n) start_d <= 1'b0;
        else        start_d <= start_i;
    end

    assign rise_o = start_i & ~start_d;
endmodule

// File: rtl/ssc_chan_pick.sv
module ssc_chan_pick #(
    parameter int NCH   = 4,
    parameter int IDX_W = 2
) (
    input  logic [NCH-1:0]   pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ssc_conv_core.sv
module ssc_conv_core #(
    parameter int CONV_CLKS = 16,
    parameter int CNT_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic last_o
);
    logic [CNT_W-1:0] cnt_q;

    assign last_o = run_i && tick_i && (cnt_q == CNT_W'(CONV_CLKS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (run_i && tick_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/ssc_result_bank.sv
module ssc_result_bank #(
    parameter int NCH    = 4,
    parameter int CODE_W = 14,
    parameter int IDX_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_i,
    input  logic [NCH*CODE_W-1:0] ain_i,
    input  logic                  wr_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    output logic [NCH*CODE_W-1:0] res_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic [CODE_W-1:0] held_q;
        logic [CODE_W-1:0] res_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q <= '0;
                res_q  <= '0;
            end else begin
                if (cap_i) held_q <= ain_i[g*CODE_W +: CODE_W];
                if (wr_i && (wr_idx_i == IDX_W'(g))) res_q <= held_q;
            end
        end

        assign res_o[g*CODE_W +: CODE_W] = res_q;
    end
endmodule

// File: rtl/ssc_seq_top.sv
module ssc_seq_top #(
    parameter int NCH       = 4,
    parameter int CODE_W    = 14,
    parameter int CONV_CLKS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  mode_sw_i,
    input  logic [NCH-1:0]        pin_sel_i,
    input  logic                  ext_clk_sel_i,
    input  logic                  ext_tick_i,
    input  logic                  reg_wr_i,
    input  logic [NCH-1:0]        reg_wdata_i,
    input  logic                  standby_n_i,
    input  logic [NCH*CODE_W-1:0] ain_i,
    output logic [NCH-1:0]        hold_o,
    output logic                  busy_o,
    output logic                  eoc_o,
    output logic [NCH*CODE_W-1:0] res_o,
    output logic                  pwr_save_o
);
    import ssc_pkg::*;

    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CNT_W = (CONV_CLKS > 1) ? $clog2(CONV_CLKS) : 1;

    ssc_state_e       state_q, state_d;
    logic [NCH-1:0]   pend_q;
    logic [NCH-1:0]   sw_sel_q;
    logic [IDX_W-1:0] cur_q;
    logic             ext_q;
    logic             busy_q, eoc_q, pwr_q;
    logic [NCH-1:0]   hold_q;

    logic             start_rise;
    logic             accept;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             conv_last;
    logic             tick;
    logic             in_scan, in_conv;
    logic             pick_now, finish;
    logic [NCH-1:0]   sel_now;

    ssc_start_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .rise_o (start_rise)
    );

    ssc_chan_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
        .pend_i(pend_q),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    assign in_scan = (state_q == ST_SCAN);
    assign in_conv = (state_q == ST_CONV);
    assign tick    = ext_q ? ext_tick_i : 1'b1;

    ssc_conv_core #(.CONV_CLKS(CONV_CLKS), .CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(in_scan),
        .run_i  (in_conv),
        .tick_i (tick),
        .last_o (conv_last)
    );

    assign accept   = (state_q == ST_IDLE) && standby_n_i && start_rise;
    assign sel_now  = mode_sw_i ? sw_sel_q : pin_sel_i;
    assign pick_now = (in_scan || (in_conv && conv_last)) && pick_any;
    assign finish   = (in_scan || (in_conv && conv_last)) && !pick_any;

    ssc_result_bank #(.NCH(NCH), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (accept),
        .ain_i   (ain_i),
        .wr_i    (in_conv && conv_last),
        .wr_idx_i(cur_q),
        .res_o   (res_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!standby_n_i) state_d = ST_SLEEP;
                else if (accept)  state_d = ST_SCAN;
            end
            ST_SCAN:  state_d = pick_any ? ST_CONV : ST_IDLE;
            ST_CONV: begin
                if (conv_last) state_d = pick_any ? ST_CONV : ST_IDLE;
            end
            ST_SLEEP: begin
                if (standby_n_i) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and datapath control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            hold_q   <= '0;
            eoc_q    <= 1'b0;
            pwr_q    <= 1'b0;
            pend_q   <= '0;
            cur_q    <= '0;
            ext_q    <= 1'b0;
            sw_sel_q <= '1;
        end else begin
            if (reg_wr_i) sw_sel_q <= reg_wdata_i;
            eoc_q <= in_conv && conv_last;
            pwr_q <= (state_d == ST_SLEEP);
            if (accept) begin
                busy_q <= 1'b1;
                hold_q <= '1;
                pend_q <= sel_now;
                ext_q  <= mode_sw_i & ext_clk_sel_i;
            end
            if (pick_now) begin
                cur_q            <= pick_idx;
                pend_q[pick_idx] <= 1'b0;
            end
            if (finish) begin
                busy_q <= 1'b0;
                hold_q <= '0;
            end
        end
    end

    assign busy_o     = busy_q;
    assign hold_o     = hold_q;
    assign eoc_o      = eoc_q;
    assign pwr_save_o = pwr_q;
endmodule

// File: rtl/ssc_seq_checker.sv
module ssc_seq_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           standby_n_i,
    input logic [NCH-1:0] hold_o,
    input logic           busy_o,
    input logic           eoc_o,
    input logic           pwr_save_o
);
    AST_HOLD_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(hold_o) == 0) || ($countones(hold_o) == NCH)); // R1

    AST_HOLD_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (hold_o != '0)); // R1

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !$past(start_i) && !busy_o && !pwr_save_o && standby_n_i) |=> busy_o); // R1

    AST_EOC_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |-> $past(busy_o)); // R6

    AST_EOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |=> !eoc_o); // R6

    AST_SLEEP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save_o |=> !busy_o); // R10
endmodule

bind ssc_seq_top ssc_seq_checker #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .standby_n_i(standby_n_i),
    .hold_o     (hold_o),
    .busy_o     (busy_o),
    .eoc_o      (eoc_o),
    .pwr_save_o (pwr_save_o)
);

// File: tb/ssc_seq_top_tb.sv
module ssc_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_sw_i = 1'b0;
    logic [3:0]  pin_sel_i = '0;
    logic        ext_clk_sel_i = 1'b0;
    logic        ext_tick_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_wdata_i = '0;
    logic        standby_n_i = 1'b1;
    logic [55:0] ain_i = '0;
    logic [3:0]  hold_o;
    logic        busy_o, eoc_o, pwr_save_o;
    logic [55:0] res_o;

    int total = 0;
    int bad = 0;
    int run_id = 0;
    int cyc = 0;
    logic [13:0] shadow [4];

    always #4 clk = ~clk;

    ssc_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_sw_i(mode_sw_i),
        .pin_sel_i(pin_sel_i), .ext_clk_sel_i(ext_clk_sel_i), .ext_tick_i(ext_tick_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .standby_n_i(standby_n_i),
        .ain_i(ain_i), .hold_o(hold_o), .busy_o(busy_o), .eoc_o(eoc_o),
        .res_o(res_o), .pwr_save_o(pwr_save_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h (run %0d)", req, act, exp, run_id);
        end
    endtask

    function automatic logic [13:0] code_of(input int r, input int ch);
        return 14'((r * 373 + ch * 4099 + 17) & 16'h3FFF);
    endfunction

    function automatic int nth_set(input logic [3:0] m, input int j);
        int k = 0;
        for (int i = 0; i < 4; i++) if (m[i]) begin k++; if (k == j) return i; end
        return -1;
    endfunction

    task automatic wr_reg(input logic [3:0] v);
        @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = v;
        @(negedge clk); reg_wr_i = 1'b0;
    endtask

    // mode: 0 pins, 1 register; extc: ext_clk_sel_i value;
    // retrig/jiggle/sb_at: disturbance options
    task automatic run_seq(input logic [3:0] mask, input bit mode, input bit extc,
                           input bit retrig, input bit jiggle, input int sb_at);
        int n = $countones(mask);
        bit use_ext = mode && extc;
        int tcount = 0;
        run_id++;
        mode_sw_i = mode; ext_clk_sel_i = extc;
        if (mode) begin pin_sel_i = ~mask; wr_reg(mask); end
        else      begin pin_sel_i = mask;  wr_reg(~mask); end
        for (int c = 0; c < 4; c++) ain_i[c*14 +: 14] = code_of(run_id, c);
        @(negedge clk);
        start_i = 1'b1; ext_tick_i = 1'b1;  // edge 0 tick value (0 % 3 == 0)
        for (int m = 1; m <= 205; m++) begin
            int e = m - 1;
            bit tk = use_ext ? (e % 3 == 0) : 1'b1;
            bit eoc_x = 1'b0;
            bit busy_x;
            @(negedge clk);
            if (e >= 2 && tk && tcount < 16 * n) begin
                tcount++;
                eoc_x = (tcount % 16 == 0);
            end
            busy_x = (n == 0) ? (e == 0) : (tcount < 16 * n);
            chk(busy_o == busy_x, "R5/R8 busy", busy_o, busy_x);
            chk(eoc_o == eoc_x, "R5/R6 eoc", eoc_o, eoc_x);
            chk(hold_o == (busy_x ? 4'hF : 4'h0), "R1 hold", hold_o, busy_x ? 4'hF : 4'h0);
            if (eoc_x) begin
                int ch = nth_set(mask, tcount / 16);
                shadow[ch] = code_of(run_id, ch);
                chk(res_o[ch*14 +: 14] == shadow[ch], "R7 slot at eoc",
                    res_o[ch*14 +: 14], shadow[ch]);
            end
            // drive for edge m
            start_i = (retrig && m == 5) ? 1'b1 : 1'b0;  // R9 retrigger
            ext_tick_i = (m % 3 == 0);
            if (m == 1) ain_i = ~ain_i;                    // R2 inputs move after hold
            if (jiggle && m == 3) begin
                pin_sel_i = ~pin_sel_i; reg_wr_i = 1'b1; reg_wdata_i = ~mask; // R2
            end else reg_wr_i = 1'b0;
            if (sb_at != 0 && m == sb_at) standby_n_i = 1'b0;
        end
        chk(busy_o == 1'b0, "R6 busy end", busy_o, 0);
        for (int c = 0; c < 4; c++)
            chk(res_o[c*14 +: 14] == shadow[c], "R7 slots kept", res_o[c*14 +: 14], shadow[c]);
        if (sb_at != 0) begin
            chk(pwr_save_o == 1'b1, "R10 sleep after sequence", pwr_save_o, 1);
            @(negedge clk); standby_n_i = 1'b1;
            @(negedge clk);
            chk(pwr_save_o == 1'b0, "R10 wake", pwr_save_o, 0);
        end
    endtask

    initial begin
        for (int c = 0; c < 4; c++) shadow[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy_o == 0, "R11 busy", busy_o, 0);
        chk(eoc_o == 0, "R11 eoc", eoc_o, 0);
        chk(hold_o == 0, "R11 hold", hold_o, 0);
        chk(pwr_save_o == 0, "R11 pwr", pwr_save_o, 0);
        chk(res_o == 0, "R11/R7 slots", res_o, 0);

        // R3: pin mode, external clock select must not matter
        for (int k = 0; k < 16; k++) run_seq(4'(k), 1'b0, 1'b1, 0, 0, 0);
        // R4: register mode, system clock
        for (int k = 0; k < 16; k++) run_seq(4'(k), 1'b1, 1'b0, 0, 0, 0);
        // R4: register mode, external ticks every third edge
        for (int k = 0; k < 16; k++) run_seq(4'(k), 1'b1, 1'b1, 0, 0, 0);
        run_seq(4'b1010, 1'b1, 1'b0, 1, 0, 0);   // R9
        run_seq(4'b0110, 1'b0, 1'b0, 0, 1, 0);   // R2 pins
        run_seq(4'b1001, 1'b1, 1'b0, 0, 1, 0);   // R2 register
        run_seq(4'b1011, 1'b0, 1'b0, 0, 0, 4);   // R10 standby mid-sequence

        // R10 standby while idle: starts ignored
        @(negedge clk); standby_n_i = 1'b0;
        @(negedge clk);
        chk(pwr_save_o == 1, "R10 enter sleep", pwr_save_o, 1);
        start_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(busy_o == 0, "R10 start ignored", busy_o, 0);
            chk(pwr_save_o == 1, "R10 stays asleep", pwr_save_o, 1);
        end
        start_i = 1'b0; standby_n_i = 1'b1;
        @(negedge clk);
        chk(pwr_save_o == 0, "R10 leave sleep", pwr_save_o, 0);
        for (int c = 0; c < 4; c++)
            chk(res_o[c*14 +: 14] == shadow[c], "R10 slots untouched", res_o[c*14 +: 14], shadow[c]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule